// File: doc/BRIEF.md
# Line Flush Scheduler and Burst Packetizer

This block takes write lines that are ready to leave a set of line buffers and moves them onto a 32-bit downstream bus. Each line holds four dwords (16 bytes), a 16-bit byte-valid mask and the line number of its aligned 16-byte address. A line enters through a valid/ready schedule port. It waits in a four-entry queue, and lines leave the queue in the order they were scheduled. When the head of the queue is ready, the block raises a bus request. After the grant it sends the line as a stream of data phases, each with an address, data, byte enables and a last flag.

A line with exactly one valid dword goes out as a single transfer. A line with two or more valid dwords goes out as one burst. The burst runs from the lowest valid dword to the highest, and the address steps by 4 on each phase. A dword inside that range with no valid bytes is still sent, with all byte enables deasserted. All valid bytes of one dword travel in one phase, with the matching enables. A burst never carries data from two lines. When the last phase of a line is accepted, the block gives a one-cycle buffer-free pulse that carries the buffer index. A line with no valid bytes is released without touching the bus.

Back-pressure works as follows. A schedule beat is taken on a rising edge where `sched_valid` and `sched_ready` are both high. `sched_ready` drops only while the queue is full. A beat for a buffer index that is already queued is taken but dropped. A data phase is presented with `ph_valid` and stays stable until `ph_ready` is high on a rising edge. The next phase, or the end of the line, follows only after that.

Top module: `line_flush_packetizer`

## Requirements
- R1: An accepted schedule leads to `bus_req` going high. `bus_req` stays high from then until the last phase of that line is accepted, and `ph_valid` is never high unless `bus_req` is high. Phases start only after `bus_gnt` has been seen high.
- R2: Lines are released, and their phases sent, strictly in the order their schedule beats were accepted.
- R3: A line with valid bytes in exactly one dword is sent as one phase, with `ph_burst`=0 and `ph_last`=1.
- R4: A line with two or more valid dwords is sent as one burst with `ph_burst`=1. The burst starts at the address of the lowest valid dword, which is the line number shifted left by 4 plus the dword index times 4. Each following phase has the address plus 4, and the burst ends with `ph_last`=1 on the highest valid dword.
- R5: In each phase, `ph_be[k]` equals byte-valid bit 4*d+k of dword d. `ph_data` is bits 32*d+31..32*d of the line data. A dword with no valid bytes inside a burst has `ph_be`=0.
- R6: After the last phase of a line is accepted, `ph_valid` is low on the next cycle. Each line is a separate packet.
- R7: While `ph_valid` is high and `ph_ready` is low, `ph_valid`, `ph_addr`, `ph_data`, `ph_be`, `ph_last` and `ph_burst` hold their values.
- R8: The cycle after the last phase of a line is accepted, `free_valid` is high for exactly one cycle, with `free_buf` equal to that line's buffer index.
- R9: A schedule beat whose buffer index is already held in the queue is taken and dropped. The buffer is flushed once, with the first data, and freed once.
- R10: A line with no valid bytes is freed with no data phase and without raising `bus_req`.
- R11: During and right after reset, `bus_req`, `ph_valid` and `free_valid` are 0 and `sched_ready` is 1.
- R12: While four lines are queued, `sched_ready` is 0 and a new schedule beat is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | A schedule beat is offered |
| sched_ready | output | 1 | The queue can take a beat |
| sched_buf | input | 3 | Index of the buffer being scheduled |
| sched_line | input | 28 | Line number (byte address divided by 16) |
| sched_bvalid | input | 16 | Byte-valid mask; bit 4*d+k is byte k of dword d |
| sched_data | input | 128 | Line data; dword d sits at bits 32*d+31..32*d |
| bus_req | output | 1 | Request for the downstream bus |
| bus_gnt | input | 1 | Grant for the downstream bus |
| ph_valid | output | 1 | A data phase is presented |
| ph_ready | input | 1 | The bus accepts the phase |
| ph_addr | output | 32 | Dword-aligned byte address of the phase |
| ph_data | output | 32 | Phase data |
| ph_be | output | 4 | Byte enables, active high |
| ph_last | output | 1 | Last phase of the line |
| ph_burst | output | 1 | The line is sent as a burst (1) or as a single transfer (0) |
| free_valid | output | 1 | One-cycle pulse: the buffer has been flushed |
| free_buf | output | 3 | Index of the freed buffer |

## Verification
Duplicate rejection and a full queue are the hardest states to reach from the ports. The engine normally drains the head line within a few cycles, so the queue never builds up. The bench holds `bus_gnt` low while it schedules several lines, which keeps every line queued. It can then offer a repeated buffer index, or a fifth line, and check `sched_ready` and the later release order once the grant comes back. Phase acceptance is paced by a pseudo-random `ph_ready`, so the hold-stable rule and address stepping are checked under stalls.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_FREE = 2'd3
  } lfp_state_e;
endpackage

// File: rtl/lfp_sched_queue.sv
module lfp_sched_queue #(
  parameter int DEPTH  = 4,
  parameter int BIDX_W = 3,
  parameter int LINE_W = 28,
  parameter int LINE_B = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BIDX_W-1:0]     in_buf,
  input  logic [LINE_W-1:0]     in_line,
  input  logic [LINE_B-1:0]     in_bv,
  input  logic [LINE_B*8-1:0]   in_data,
  input  logic                  pop,
  output logic                  hd_valid,
  output logic [BIDX_W-1:0]     hd_buf,
  output logic [LINE_W-1:0]     hd_line,
  output logic [LINE_B-1:0]     hd_bv,
  output logic [LINE_B*8-1:0]   hd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [BIDX_W-1:0]   buf_q  [DEPTH];
  logic [LINE_W-1:0]   line_q [DEPTH];
  logic [LINE_B-1:0]   bv_q   [DEPTH];
  logic [LINE_B*8-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]    occ;
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    cnt;
  logic                dup, push;

  // a buffer index already waiting (or flushing) must not be queued twice
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ[i] && (buf_q[i] == in_buf)) dup = 1'b1;
    end
  end

  assign in_ready = (cnt != CNT_W'(DEPTH));
  assign push     = in_valid && in_ready && !dup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      occ    <= '0;
    end else begin
      if (push) begin
        occ[wr_ptr] <= 1'b1;
        wr_ptr      <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        occ[rd_ptr] <= 1'b0;
        rd_ptr      <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      buf_q[wr_ptr]  <= in_buf;
      line_q[wr_ptr] <= in_line;
      bv_q[wr_ptr]   <= in_bv;
      data_q[wr_ptr] <= in_data;
    end
  end

  assign hd_valid = occ[rd_ptr];
  assign hd_buf   = buf_q[rd_ptr];
  assign hd_line  = line_q[rd_ptr];
  assign hd_bv    = bv_q[rd_ptr];
  assign hd_data  = data_q[rd_ptr];
endmodule

// File: rtl/lfp_dword_scan.sv
module lfp_dword_scan #(
  parameter int LINE_DW = 4
) (
  input  logic [LINE_DW*4-1:0]         bv,
  output logic [$clog2(LINE_DW)-1:0]   lo,
  output logic [$clog2(LINE_DW)-1:0]   hi,
  output logic                         any,
  output logic                         multi
);
  localparam int DWI_W = $clog2(LINE_DW);

  logic [LINE_DW-1:0] has;

  for (genvar d = 0; d < LINE_DW; d++) begin : g_dw
    assign has[d] = |bv[d*4 +: 4];
  end

  always_comb begin
    lo = '0;
    for (int d = LINE_DW - 1; d >= 0; d--) begin
      if (has[d]) lo = DWI_W'(d);
    end
    hi = '0;
    for (int d = 0; d < LINE_DW; d++) begin
      if (has[d]) hi = DWI_W'(d);
    end
  end

  assign any   = |has;
  assign multi = ($countones(has) > 1);
endmodule

// File: rtl/lfp_burst_engine.sv
module lfp_burst_engine
  import lfp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BIDX_W  = 3,
  parameter int LINE_DW = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hd_valid,
  input  logic [BIDX_W-1:0]                 hd_buf,
  input  logic [ADDR_W-$clog2(LINE_DW)-3:0] hd_line,
  input  logic [LINE_DW*4-1:0]              hd_bv,
  input  logic [LINE_DW*32-1:0]             hd_data,
  input  logic [$clog2(LINE_DW)-1:0]        line_lo,
  input  logic [$clog2(LINE_DW)-1:0]        line_hi,
  input  logic                              line_any,
  input  logic                              line_multi,
  output logic                              pop,
  output logic                              bus_req,
  input  logic                              bus_gnt,
  output logic                              ph_valid,
  input  logic                              ph_ready,
  output logic [ADDR_W-1:0]                 ph_addr,
  output logic [31:0]                       ph_data,
  output logic [3:0]                        ph_be,
  output logic                              ph_last,
  output logic                              ph_burst,
  output logic                              free_valid,
  output logic [BIDX_W-1:0]                 free_buf
);
  localparam int DWI_W = $clog2(LINE_DW);

  lfp_state_e       state;
  logic [DWI_W-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (hd_valid) begin
          if (line_any) begin
            state <= ST_REQ;
            cur   <= line_lo;
          end else begin
            state <= ST_FREE;
          end
        end
        ST_REQ:  if (bus_gnt) state <= ST_XFER;
        ST_XFER: if (ph_ready) begin
          if (cur == line_hi) state <= ST_FREE;
          else                cur   <= cur + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req    = (state == ST_REQ) || (state == ST_XFER);
  assign ph_valid   = (state == ST_XFER);
  assign ph_addr    = {hd_line, cur, 2'b00};
  assign ph_data    = hd_data[cur*32 +: 32];
  assign ph_be      = hd_bv[cur*4 +: 4];
  assign ph_last    = (cur == line_hi);
  assign ph_burst   = line_multi;
  assign free_valid = (state == ST_FREE);
  assign free_buf   = hd_buf;
  assign pop        = (state == ST_FREE);
endmodule

// File: rtl/line_flush_packetizer.sv
module line_flush_packetizer #(
  parameter int ADDR_W  = 32,
  parameter int NUM_BUF = 8,
  parameter int LINE_DW = 4,
  parameter int QDEPTH  = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      sched_valid,
  output logic                                      sched_ready,
  input  logic [$clog2(NUM_BUF)-1:0]                sched_buf,
  input  logic [ADDR_W-$clog2(LINE_DW)-3:0]         sched_line,
  input  logic [LINE_DW*4-1:0]                      sched_bvalid,
  input  logic [LINE_DW*32-1:0]                     sched_data,
  output logic                                      bus_req,
  input  logic                                      bus_gnt,
  output logic                                      ph_valid,
  input  logic                                      ph_ready,
  output logic [ADDR_W-1:0]                         ph_addr,
  output logic [31:0]                               ph_data,
  output logic [3:0]                                ph_be,
  output logic                                      ph_last,
  output logic                                      ph_burst,
  output logic                                      free_valid,
  output logic [$clog2(NUM_BUF)-1:0]                free_buf
);
  localparam int BIDX_W = $clog2(NUM_BUF);
  localparam int DWI_W  = $clog2(LINE_DW);
  localparam int LINE_W = ADDR_W - DWI_W - 2;
  localparam int LINE_B = LINE_DW * 4;

  logic                hd_valid, pop;
  logic [BIDX_W-1:0]   hd_buf;
  logic [LINE_W-1:0]   hd_line;
  logic [LINE_B-1:0]   hd_bv;
  logic [LINE_B*8-1:0] hd_data;
  logic [DWI_W-1:0]    lo, hi;
  logic                any_v, multi_v;

  lfp_sched_queue #(
    .DEPTH(QDEPTH), .BIDX_W(BIDX_W), .LINE_W(LINE_W), .LINE_B(LINE_B)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sched_valid), .in_ready(sched_ready),
    .in_buf(sched_buf), .in_line(sched_line),
    .in_bv(sched_bvalid), .in_data(sched_data),
    .pop(pop), .hd_valid(hd_valid), .hd_buf(hd_buf),
    .hd_line(hd_line), .hd_bv(hd_bv), .hd_data(hd_data)
  );

  lfp_dword_scan #(.LINE_DW(LINE_DW)) u_scan (
    .bv(hd_bv), .lo(lo), .hi(hi), .any(any_v), .multi(multi_v)
  );

  lfp_burst_engine #(
    .ADDR_W(ADDR_W), .BIDX_W(BIDX_W), .LINE_DW(LINE_DW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .hd_valid(hd_valid), .hd_buf(hd_buf), .hd_line(hd_line),
    .hd_bv(hd_bv), .hd_data(hd_data),
    .line_lo(lo), .line_hi(hi), .line_any(any_v), .line_multi(multi_v),
    .pop(pop), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_addr(ph_addr),
    .ph_data(ph_data), .ph_be(ph_be), .ph_last(ph_last), .ph_burst(ph_burst),
    .free_valid(free_valid), .free_buf(free_buf)
  );
endmodule

// File: rtl/lfp_checker.sv
module lfp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              ph_valid,
  input logic              ph_ready,
  input logic [ADDR_W-1:0] ph_addr,
  input logic [31:0]       ph_data,
  input logic [3:0]        ph_be,
  input logic              ph_last,
  input logic              ph_burst,
  input logic              free_valid
);
  assert_phase_under_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid |-> bus_req);

  assert_single_is_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_burst) |-> ph_last);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_ready && !ph_last) |=>
      (ph_valid && ph_addr == $past(ph_addr) + ADDR_W'(4)));

  assert_no_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_ready && ph_last) |=> !ph_valid);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_ready) |=>
      (ph_valid && $stable(ph_addr) && $stable(ph_data) && $stable(ph_be)
       && $stable(ph_last) && $stable(ph_burst)));

  assert_free_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_ready && ph_last) |=> free_valid);

  assert_free_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> !free_valid);
endmodule

bind line_flush_packetizer lfp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .ph_valid(ph_valid),
  .ph_ready(ph_ready), .ph_addr(ph_addr), .ph_data(ph_data), .ph_be(ph_be),
  .ph_last(ph_last), .ph_burst(ph_burst), .free_valid(free_valid)
);

// File: tb/tb_line_flush_packetizer.sv
`timescale 1ns/1ps
module tb_line_flush_packetizer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sched_valid = 1'b0;
  logic         sched_ready;
  logic [2:0]   sched_buf = '0;
  logic [27:0]  sched_line = '0;
  logic [15:0]  sched_bvalid = '0;
  logic [127:0] sched_data = '0;
  logic         bus_req;
  logic         bus_gnt = 1'b0;
  logic         ph_valid;
  logic         ph_ready = 1'b0;
  logic [31:0]  ph_addr;
  logic [31:0]  ph_data;
  logic [3:0]   ph_be;
  logic         ph_last, ph_burst, free_valid;
  logic [2:0]   free_buf;

  line_flush_packetizer dut (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_ready(sched_ready),
    .sched_buf(sched_buf), .sched_line(sched_line), .sched_bvalid(sched_bvalid),
    .sched_data(sched_data), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_addr(ph_addr), .ph_data(ph_data),
    .ph_be(ph_be), .ph_last(ph_last), .ph_burst(ph_burst),
    .free_valid(free_valid), .free_buf(free_buf)
  );

  always #2 clk = ~clk;   // 250 MHz

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;

  // stimulus table: {buffer, line number, byte-valid mask}
  localparam logic [46:0] VEC [8] = '{
    {3'd1, 28'h0001000, 16'h000F},   // single, dword 0
    {3'd2, 28'h0001001, 16'hF000},   // single, dword 3
    {3'd3, 28'h0002002, 16'h0102},   // burst with gap dword 1
    {3'd4, 28'h0003003, 16'hFFFF},   // full line
    {3'd5, 28'h0004004, 16'h0030},   // single, partial dword 1
    {3'd6, 28'h0005005, 16'h8001},   // burst dw0..dw3, two gaps
    {3'd7, 28'h0006006, 16'h0F00},   // single, dword 2
    {3'd0, 28'h0007007, 16'h0C60}    // burst dw1..dw2 partial bytes
  };

  // capture of accepted phases and frees
  logic [31:0] cap_addr [64];
  logic [31:0] cap_data [64];
  logic [3:0]  cap_be   [64];
  logic        cap_last [64];
  logic        cap_bst  [64];
  int          cap_n = 0;
  logic [2:0]  cap_free [16];
  int          free_n = 0;
  bit          req_seen = 0;

  logic [31:0] exp_addr [64];
  logic [31:0] exp_data [64];
  logic [3:0]  exp_be   [64];
  logic        exp_last [64];
  logic        exp_bst  [64];
  int          exp_n = 0;
  logic [2:0]  exp_free [16];
  int          exp_fn = 0;

  bit         gnt_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ph_ready = lfsr[0] | lfsr[2];
    bus_gnt  = gnt_en && bus_req;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req) req_seen = 1;
      if (ph_valid && ph_ready && cap_n < 64) begin
        cap_addr[cap_n] = ph_addr; cap_data[cap_n] = ph_data; cap_be[cap_n] = ph_be;
        cap_last[cap_n] = ph_last; cap_bst[cap_n] = ph_burst; cap_n++;
      end
      if (free_valid && free_n < 16) begin
        cap_free[free_n] = free_buf; free_n++;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=<150000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_data(input int seed);
    logic [127:0] r;
    for (int d = 0; d < 4; d++) r[d*32 +: 32] = {8'(seed), 8'(d + 1), 16'h5A3C ^ 16'(seed * 7)};
    return r;
  endfunction

  task automatic clear_all();
    cap_n = 0; free_n = 0; exp_n = 0; exp_fn = 0; req_seen = 0;
  endtask

  // build the expected phases of one line from the requirements
  task automatic add_exp(input logic [2:0] b, input logic [27:0] ln,
                         input logic [15:0] bv, input logic [127:0] dat);
    int lo = -1, hi = -1;
    for (int d = 0; d < 4; d++) if (|bv[d*4 +: 4]) begin
      if (lo < 0) lo = d;
      hi = d;
    end
    if (lo >= 0) begin
      for (int d = lo; d <= hi; d++) begin
        exp_addr[exp_n] = {ln, 2'(d), 2'b00};
        exp_data[exp_n] = dat[d*32 +: 32];
        exp_be[exp_n]   = bv[d*4 +: 4];
        exp_last[exp_n] = (d == hi);
        exp_bst[exp_n]  = (lo != hi);
        exp_n++;
      end
    end
    exp_free[exp_fn] = b; exp_fn++;
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " phase count (R3/R4)"}, 128'(cap_n), 128'(exp_n));
    for (int j = 0; j < exp_n && j < cap_n; j++) begin
      chk({tag, " R4 addr"},  128'(cap_addr[j]), 128'(exp_addr[j]));
      chk({tag, " R5 data"},  128'(cap_data[j]), 128'(exp_data[j]));
      chk({tag, " R5 be"},    128'(cap_be[j]),   128'(exp_be[j]));
      chk({tag, " R3 last"},  128'(cap_last[j]), 128'(exp_last[j]));
      chk({tag, " R4 burst"}, 128'(cap_bst[j]),  128'(exp_bst[j]));
    end
    chk({tag, " R8 free count"}, 128'(free_n), 128'(exp_fn));
    for (int j = 0; j < exp_fn && j < free_n; j++)
      chk({tag, " R2 free order"}, 128'(cap_free[j]), 128'(exp_free[j]));
  endtask

  // called at a negedge; returns whether the beat was taken
  task automatic sched(input logic [2:0] b, input logic [27:0] ln, input logic [15:0] bv,
                       input logic [127:0] dat, output bit acc);
    sched_valid = 1'b1; sched_buf = b; sched_line = ln; sched_bvalid = bv; sched_data = dat;
    acc = sched_ready;
    @(negedge clk);
    sched_valid = 1'b0;
  endtask

  task automatic wait_frees(input int n);
    while (free_n < n) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    bit acc;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 bus_req", 128'(bus_req), 128'(0));
    chk("R11 ph_valid", 128'(ph_valid), 128'(0));
    chk("R11 free_valid", 128'(free_valid), 128'(0));
    chk("R11 sched_ready", 128'(sched_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release", 128'({bus_req, ph_valid, free_valid, sched_ready}), 128'(4'b0001));
    gnt_en = 1'b1;

    // table walk: one line at a time
    for (int i = 0; i < 8; i++) begin
      clear_all();
      sched(VEC[i][46:44], VEC[i][43:16], VEC[i][15:0], mk_data(i), acc);
      chk("R1 accepted", 128'(acc), 128'(1));
      add_exp(VEC[i][46:44], VEC[i][43:16], VEC[i][15:0], mk_data(i));
      wait_frees(1);
      chk("R1 bus_req seen", 128'(req_seen), 128'(1));
      compare_all($sformatf("vec%0d", i));
    end

    // R2/R6: three lines queued behind a withheld grant
    clear_all(); gnt_en = 1'b0;
    sched(3'd5, 28'h0A00000, 16'hFF0F, mk_data(20), acc);
    add_exp(3'd5, 28'h0A00000, 16'hFF0F, mk_data(20));
    sched(3'd2, 28'h0A00001, 16'h0100, mk_data(21), acc);
    add_exp(3'd2, 28'h0A00001, 16'h0100, mk_data(21));
    sched(3'd7, 28'h0A00002, 16'hF0F0, mk_data(22), acc);
    add_exp(3'd7, 28'h0A00002, 16'hF0F0, mk_data(22));
    repeat (5) @(negedge clk);
    chk("R1 no phase before grant", 128'(cap_n), 128'(0));
    gnt_en = 1'b1;
    wait_frees(3);
    compare_all("order R2 R6");

    // R9: duplicate index dropped
    clear_all(); gnt_en = 1'b0;
    sched(3'd3, 28'h0B00000, 16'h00FF, mk_data(30), acc);
    add_exp(3'd3, 28'h0B00000, 16'h00FF, mk_data(30));
    sched(3'd3, 28'h0B00009, 16'hFFFF, mk_data(31), acc);
    chk("R9 duplicate beat taken", 128'(acc), 128'(1));
    gnt_en = 1'b1;
    wait_frees(1);
    repeat (20) @(negedge clk);
    compare_all("dup R9");

    // R10: empty line
    clear_all();
    sched(3'd6, 28'h0C00000, 16'h0000, mk_data(40), acc);
    add_exp(3'd6, 28'h0C00000, 16'h0000, mk_data(40));
    wait_frees(1);
    chk("R10 no bus request", 128'(req_seen), 128'(0));
    compare_all("empty R10");

    // R12: full queue
    clear_all(); gnt_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sched(3'(k), 28'h0D00000 + 28'(k), 16'h0F0F, mk_data(50 + k), acc);
      add_exp(3'(k), 28'h0D00000 + 28'(k), 16'h0F0F, mk_data(50 + k));
    end
    chk("R12 sched_ready low when full", 128'(sched_ready), 128'(0));
    sched(3'd4, 28'h0D00004, 16'hFFFF, mk_data(60), acc);
    chk("R12 fifth beat refused", 128'(acc), 128'(0));
    gnt_en = 1'b1;
    wait_frees(4);
    repeat (10) @(negedge clk);
    compare_all("full R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule